// File: doc/BRIEF.md
# Cascadable TDM256 Serial Output Port

This block produces the serial data line of a time-division-multiplexed output frame that lasts 256 bit-clock periods and is cut into eight slots of 32 bit clocks. The device writes its own left and right 24-bit words into the first two slots. A serial stream arriving from the previous device of a daisy chain is copied to the output 64 bit clocks later, so it lands two slots further on. With four such ports chained, the last one in line carries all eight channels.

Bit clock and frame clock come from outside; the port is always a slave. The block runs on a faster core clock. It synchronises the three serial inputs and acts on the bit-clock edges it detects. A static select chooses left-justified slots (data right after the frame edge) or the I2S-style variant (one bit clock later). The device at the far end of the chain ties its chain input low, so slots that nobody fills stay zero.

Top module: `tdm_cascade_port`

## Requirements
- R1: A frame start is the first bit-clock rising edge at which the frame clock is sampled high after being sampled low. Bit positions are counted from that edge, with 32 positions per slot, and the count restarts at every frame start, even when the previous frame was shorter than 256 bit clocks.
- R2: Slot 0 carries the left word and slot 1 the right word, 24 bits each, most significant bit first. Bits 24 to 31 of each of these slots are driven 0.
- R3: With align_i2s = 0, the most significant bit of slot 0 is driven at the first bit-clock falling edge after the frame-start rising edge. With align_i2s = 1, each slot's data starts one bit clock later.
- R4: chain_in is sampled on bit-clock rising edges. Each sampled bit reappears on chain_out exactly 64 bit clocks later, in slots 2 to 7.
- R5: Relayed bits that would fall into slots 0 or 1 (the previous device's slots 6 and 7) are discarded. The device's own data always wins there.
- R6: left_word and right_word are captured only at a frame start. Changing them during a frame has no effect on chain_out until the next frame.
- R7: chain_out changes only in response to a bit-clock falling edge. It is stable between falling edges.
- R8: While rst_n is low at a core-clock edge, chain_out is 0. After reset, chain_out stays 0 until the first frame start has been seen.
- R9: Frame-clock high times from one bit-clock period up to 255 periods give the same output.
- R10: In a chain of four ports, the port n hops away from the output (n = 0 to 3) has its left and right words in slots 2n and 2n+1 of the final output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_clk | input | 1 | Serial bit clock |
| frame_clk | input | 1 | Frame clock; its rising edge marks the frame start |
| chain_in | input | 1 | TDM stream from the previous device (tie low at chain end) |
| align_i2s | input | 1 | 0: left-justified slots, 1: I2S-style one-bit delay |
| left_word | input | DATA_W | Own left sample |
| right_word | input | DATA_W | Own right sample |
| chain_out | output | 1 | Serial TDM output |

## Verification
Two functions meet in one cycle at every falling edge inside slots 0 and 1: a relayed bit from the upstream stream is due for output, and the own word has to be driven in its place. The bench drives chain_in with random bits in every slot, including the two slots that must be discarded. Own-slot outputs are judged against the latched word, and a mismatch that equals the delayed upstream bit is reported under R5. The frame start and a mid-frame word change also coincide with relay traffic: the words change 40 bit clocks into selected frames, and own slots must keep the value captured at the frame edge.

// File: rtl/tdm_cascade_pkg.sv
// Shared definitions for the cascadable TDM output port.
// Assumes: exactly two own channels (left, right) per device.
package tdm_cascade_pkg;

    // Slot alignment relative to the frame edge.
    typedef enum logic {
        ALIGN_MSB = 1'b0,
        ALIGN_I2S = 1'b1
    } tdm_align_e;

    // Number of slots each device fills with its own words.
    localparam int OWN_SLOTS = 2;

endpackage

// File: rtl/tdm_pin_sync.sv
// Brings the bit clock, frame clock and chain data into the core clock
// domain through a STAGES-deep register chain and derives single-cycle
// rising and falling bit-clock events. All three pins travel together,
// so data and frame clock line up with the bit-clock edge they belong to.
// Assumes: the core clock runs at least 4x the bit clock.
module tdm_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_clk,
    input  logic frame_clk,
    input  logic data_in,
    output logic bck_rise,
    output logic bck_fall,
    output logic frame_s,
    output logic data_s
);

    localparam int PINS = 3;

    logic [STAGES-1:0][PINS-1:0] stg;
    logic [PINS-1:0]             raw;
    logic [PINS-1:0]             last;
    logic                        bck_q;

    assign raw  = {data_in, frame_clk, bit_clk};
    assign last = stg[STAGES-1];

    // Synchronizer chain: one stage or a shifted stack, chosen by STAGES.
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= raw;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= {stg[STAGES-2:0], raw};
            end
        end
    endgenerate

    // Previous synchronized bit clock, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bck_q <= 1'b0;
        else        bck_q <= last[0];
    end

    assign bck_rise = last[0] & ~bck_q;
    assign bck_fall = ~last[0] & bck_q;
    assign frame_s  = last[1];
    assign data_s   = last[2];

endmodule

// File: rtl/tdm_frame_timer.sv
// Finds the frame start (frame clock sampled high after low on a bit-clock
// rise) and counts bit positions in the frame. The counter wraps at the
// frame length and restarts on every frame start. A sticky flag records
// that framing has been seen since reset.
// Assumes: frame length is a power of two.
module tdm_frame_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             frame_s,
    output logic             frame_start,
    output logic [CNT_W-1:0] pos_cnt,
    output logic             framed
);

    logic frame_prev;

    assign frame_start = rise & frame_s & ~frame_prev;

    // Position counter, previous frame level and framed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_cnt    <= '0;
            frame_prev <= 1'b0;
            framed     <= 1'b0;
        end else if (rise) begin
            frame_prev <= frame_s;
            pos_cnt    <= frame_start ? '0 : pos_cnt + 1'b1;
            if (frame_start) framed <= 1'b1;
        end
    end

    a_r1_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (pos_cnt == '0));

    a_r8_framed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        framed |=> framed);

endmodule

// File: rtl/tdm_relay_line.sv
// Fixed delay line for the upstream TDM stream: one bit enters on each
// bit-clock rise and leaves DEPTH rises later.
// Assumes: DEPTH >= 2.
module tdm_relay_line #(
    parameter int DEPTH = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift,
    input  logic din,
    output logic tap
);

    logic [DEPTH-1:0] line_q;

    // Shift register advanced once per bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n)     line_q <= '0;
        else if (shift) line_q <= {line_q[DEPTH-2:0], din};
    end

    assign tap = line_q[DEPTH-1];

endmodule

// File: rtl/tdm_cascade_port.sv
// Cascadable slave TDM output port. It writes its own left/right words
// into slots 0 and 1 and relays the upstream stream two slots later.
// The output register updates on detected bit-clock falling edges.
// Assumes: DATA_W < SLOT_W, and SLOT_W and NUM_SLOTS are powers of two.
module tdm_cascade_port
    import tdm_cascade_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int SLOT_W      = 32,
    parameter int NUM_SLOTS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_clk,
    input  logic              frame_clk,
    input  logic              chain_in,
    input  logic              align_i2s,
    input  logic [DATA_W-1:0] left_word,
    input  logic [DATA_W-1:0] right_word,
    output logic              chain_out
);

    localparam int FRAME_W = SLOT_W * NUM_SLOTS;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam int BIT_W   = $clog2(SLOT_W);
    localparam int SLOT_IW = CNT_W - BIT_W;
    localparam int WIDX_W  = $clog2(DATA_W);
    localparam int RELAY_D = OWN_SLOTS * SLOT_W;

    logic               bck_rise, bck_fall, frame_s, data_s;
    logic               frame_start, framed, relay_bit;
    logic [CNT_W-1:0]   pos_cnt, pos;
    logic [SLOT_IW-1:0] slot;
    logic [BIT_W-1:0]   bitn;
    logic [WIDX_W-1:0]  widx;
    logic [DATA_W-1:0]  hold_l, hold_r, word;
    logic               own_slot, in_data, own_bit, next_bit;
    tdm_align_e         align;

    tdm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_clk   (bit_clk),
        .frame_clk (frame_clk),
        .data_in   (chain_in),
        .bck_rise  (bck_rise),
        .bck_fall  (bck_fall),
        .frame_s   (frame_s),
        .data_s    (data_s)
    );

    tdm_frame_timer #(.CNT_W(CNT_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise        (bck_rise),
        .frame_s     (frame_s),
        .frame_start (frame_start),
        .pos_cnt     (pos_cnt),
        .framed      (framed)
    );

    tdm_relay_line #(.DEPTH(RELAY_D)) u_relay (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (bck_rise),
        .din   (data_s),
        .tap   (relay_bit)
    );

    // Own words are captured at the frame edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l <= '0;
            hold_r <= '0;
        end else if (frame_start) begin
            hold_l <= left_word;
            hold_r <= right_word;
        end
    end

    // Slot/bit decode with optional one-bit alignment delay.
    always_comb begin
        align    = tdm_align_e'(align_i2s);
        pos      = pos_cnt - ((align == ALIGN_I2S) ? CNT_W'(1) : CNT_W'(0));
        slot     = pos[CNT_W-1:BIT_W];
        bitn     = pos[BIT_W-1:0];
        own_slot = slot < SLOT_IW'(OWN_SLOTS);
        in_data  = {1'b0, bitn} < (BIT_W+1)'(DATA_W);
        widx     = WIDX_W'(DATA_W - 1 - int'(bitn));
        word     = slot[0] ? hold_r : hold_l;
        own_bit  = in_data ? word[widx] : 1'b0;
        next_bit = framed ? (own_slot ? own_bit : relay_bit) : 1'b0;
    end

    // Serial output register, updated on bit-clock falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n)        chain_out <= 1'b0;
        else if (bck_fall) chain_out <= next_bit;
    end

    a_r8_reset_low: assert property (@(posedge clk)
        !rst_n |=> (chain_out == 1'b0));

    a_r7_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !bck_fall |=> $stable(chain_out));

    a_r2_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bck_fall && framed && own_slot && !in_data) |=> (chain_out == 1'b0));

    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(hold_l) && $stable(hold_r)));

endmodule

// File: tb/sim_tdm_cascade_port.sv
module sim_tdm_cascade_port;

    localparam int DW   = 24;
    localparam int HALF = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, bck, fck, din_b, align, sel_chain;
    logic [DW-1:0] lw [4];
    logic [DW-1:0] rw [4];
    logic c0, c1, c2, c3, u0_in;

    assign u0_in = sel_chain ? c1 : din_b;

    tdm_cascade_port u3 (.clk(clk), .rst_n(rst_n), .bit_clk(bck), .frame_clk(fck),
        .chain_in(1'b0), .align_i2s(align), .left_word(lw[3]), .right_word(rw[3]), .chain_out(c3));
    tdm_cascade_port u2 (.clk(clk), .rst_n(rst_n), .bit_clk(bck), .frame_clk(fck),
        .chain_in(c3), .align_i2s(align), .left_word(lw[2]), .right_word(rw[2]), .chain_out(c2));
    tdm_cascade_port u1 (.clk(clk), .rst_n(rst_n), .bit_clk(bck), .frame_clk(fck),
        .chain_in(c2), .align_i2s(align), .left_word(lw[1]), .right_word(rw[1]), .chain_out(c1));
    tdm_cascade_port u0 (.clk(clk), .rst_n(rst_n), .bit_clk(bck), .frame_clk(fck),
        .chain_in(u0_in), .align_i2s(align), .left_word(lw[0]), .right_word(rw[0]), .chain_out(c0));

    int n_cmp = 0;
    int n_bad = 0;
    int t = 0;
    int fs = 0;
    int rst_step = 0;
    int cur_len = 256;
    int cur_hi = 1;
    bit started = 0;
    bit prev_f = 0;
    bit up [0:16383];
    logic [DW-1:0] hl [4];
    logic [DW-1:0] hr [4];

    task automatic check(input logic exp, input logic act, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: chain_out=%0b expected %0b (step %0d)", req, act, exp, t);
        end
    endtask

    // Model of the output during step t (k = position from the last rise).
    function automatic logic expected(output string req);
        int k, pos, slot, b, d, g;
        logic [DW-1:0] w;
        logic relay;
        if (!started) begin req = "R8"; return 1'b0; end
        k    = (t - 1 - fs) & 255;
        pos  = align ? ((k + 255) & 255) : k;
        slot = pos >> 5;
        b    = pos & 31;
        g    = t - 64;
        relay = (g >= rst_step) ? up[g] : 1'b0;
        if (sel_chain) begin
            d = slot >> 1;
            w = slot[0] ? hr[d] : hl[d];
            req = "R10";
            return (b < DW) ? w[DW-1-b] : 1'b0;
        end
        if (slot < 2) begin
            w = slot[0] ? hr[0] : hl[0];
            expected = (b < DW) ? w[DW-1-b] : 1'b0;
            if (pos == 0) req = "R3";
            else if (lw[0] !== hl[0] || rw[0] !== hr[0]) req = "R6";
            else if (relay !== expected) req = "R5";
            else req = "R2";
            return expected;
        end
        if (cur_len != 256) req = "R1";
        else if (cur_hi == 1 || cur_hi == 255) req = "R9";
        else req = "R4";
        return relay;
    endfunction

    task automatic do_step(input bit f, input bit d);
        logic e;
        string req;
        e = expected(req);
        @(negedge clk);
        bck = 1'b0; fck = f; din_b = d; up[t] = d;
        repeat (HALF - 1) @(negedge clk);
        check(e, c0, req);
        @(negedge clk);
        bck = 1'b1;
        repeat (HALF - 1) @(negedge clk);
        check(e, c0, "R7");
        if (f && !prev_f) begin
            fs = t;
            started = 1'b1;
            for (int i = 0; i < 4; i++) begin hl[i] = lw[i]; hr[i] = rw[i]; end
        end
        prev_f = f;
        t++;
    endtask

    task automatic new_words();
        for (int i = 0; i < 4; i++) begin
            lw[i] = DW'($urandom);
            rw[i] = DW'($urandom);
        end
    endtask

    task automatic run_frame(input int len, input int hi, input bit chg);
        cur_len = len;
        cur_hi = hi;
        for (int r = 0; r < len; r++) begin
            if (chg && r == 40) new_words();
            do_step(r < hi, 1'($urandom));
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) do_step(1'b0, 1'($urandom));
    endtask

    task automatic reset_dut(input bit new_align, input bit new_chain);
        @(negedge clk);
        rst_n = 1'b0; bck = 1'b0; fck = 1'b0;
        repeat (3) @(negedge clk);
        check(1'b0, c0, "R8");
        align = new_align;
        sel_chain = new_chain;
        started = 1'b0;
        prev_f = 1'b0;
        rst_step = t;
        repeat (2) @(negedge clk);
        check(1'b0, c0, "R8");
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bck = 1'b0; fck = 1'b0; din_b = 1'b0;
        align = 1'b0; sel_chain = 1'b0;
        new_words();
        // Reset and pre-framing output (R8).
        reset_dut(1'b0, 1'b0);
        idle(6);
        // Left-justified alignment, standalone with random upstream data.
        run_frame(256, 1, 1'b0);      // R9 shortest high time
        run_frame(256, 128, 1'b1);    // R6 mid-frame word change
        run_frame(200, 16, 1'b0);     // R1 short frame restarts count
        run_frame(256, 255, 1'b1);    // R9 longest high time
        run_frame(256, 64, 1'b0);
        run_frame(100, 50, 1'b0);     // cut by reset mid-frame
        // I2S-style alignment (R3).
        reset_dut(1'b1, 1'b0);
        idle(3);
        run_frame(256, 1, 1'b1);
        run_frame(256, 255, 1'b0);
        run_frame(256, 128, 1'b1);
        run_frame(256, 32, 1'b0);
        // Four-device chain (R10), both alignments.
        reset_dut(1'b0, 1'b1);
        idle(2);
        run_frame(256, 128, 1'b1);
        run_frame(256, 1, 1'b0);
        run_frame(256, 64, 1'b1);
        reset_dut(1'b1, 1'b1);
        idle(2);
        run_frame(256, 128, 1'b0);
        run_frame(256, 255, 1'b1);
        run_frame(256, 7, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule